// File: doc/BRIEF.md
# Downstream Command Doorbell

This block is the host-side register file through which software issues one downstream command at a time to a peripheral and collects its outcome. Software fills three staging words (second header, third header, payload), then writes the first header word with its start bit set. That single write latches the command, raises a busy flag and presents the four words to a transport backend on a valid/ready request interface. The backend later returns a completion code and a 32-bit response word.

On completion the busy flag drops and a sticky status register records a done flag, plus one error flag chosen by the completion code. When the command was a configuration read that ended cleanly, the response word replaces the second header word, so software reads the result from that register. Software clears status bits by writing ones to them. An interrupt line is raised while any status bit and its enable bit are both set. Wire framing and CRC belong to the backend and are outside this block.

Top module: `dncmd_doorbell`

## Requirements
- R1: After reset every register reads zero, busy is clear, `req_valid` is low and `irq` is low.
- R2: Register offsets are 0x00 header word 0, 0x04 header word 1, 0x08 header word 2, 0x0C data word, 0x6C interrupt enable and 0x70 status. Any other offset reads zero. Header word 2 keeps only bits 7:0. Header word 0 stores command type in bits 2:0, target select in bits 5:4 and header bytes in bits 15:8, 23:16 and 31:24. Bits 7:6 read zero, and bit 3 reads the busy flag.
- R3: A write to header word 0 with bit 3 set while idle stores the word, makes bit 3 read 1 and raises `req_valid` from the next cycle, carrying the stored words. The same write with bit 3 clear stores the fields and starts nothing.
- R4: `req_valid` stays high with unchanged request words until a cycle with `req_ready` high. It is low from the following cycle.
- R5: A `cpl_valid` pulse received after the request was accepted clears busy. A `cpl_valid` pulse that arrives while idle, or before acceptance, has no effect.
- R6: While busy, writes to offsets 0x00, 0x04, 0x08 and 0x0C are ignored.
- R7: Every accepted completion sets status bit 28. The completion code also sets one error bit: 0 sets none, 1 sets bit 6 (non-fatal), 2 sets bit 5 (fatal), 3 sets bit 4 (no response), 4 sets bit 2 (CRC), 5 sets bit 1 (wait timeout), 6 sets bit 0 (bus error) and 7 sets bit 5.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. When a completion sets a bit in the same cycle as a write clears it, the bit ends up set.
- R9: A completion with code 0 for command type 1 (get-configuration) loads `cpl_word` into header word 1. Every other type or code leaves header word 1 unchanged.
- R10: The enable register keeps only the implemented status bits (28, 6, 5, 4, 2, 1, 0). `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register write strobe qualifier |
| bus_write | input | 1 | Write when high together with bus_valid |
| bus_addr | input | ADDR_W | Register byte offset (write and read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| req_valid | output | 1 | Command presented to backend |
| req_ready | input | 1 | Backend accepts the command |
| req_hdr0 | output | 32 | Header word 0 (bit 3 shows busy) |
| req_hdr1 | output | 32 | Header word 1 |
| req_hdr2 | output | 8 | Header word 2 byte |
| req_data | output | 32 | Data word |
| cpl_valid | input | 1 | Backend completion strobe |
| cpl_code | input | 3 | Completion code |
| cpl_word | input | 32 | Response word |
| irq | output | 1 | Enabled status pending |

## Verification
The hardest case to reach is a status bit being set and cleared in the same cycle: a completion and a write-one-to-clear of bit 28 must reach the block on one clock edge. The bench holds the backend in its wait-for-completion phase. In one cycle it then drives both the clear write and `cpl_valid`, with a get-configuration command outstanding, so the same edge also exercises response capture. Completions that arrive before acceptance, or with nothing outstanding, are also forced deliberately, and the bench confirms that neither changes the status register.

// File: rtl/dncmd_pkg.sv
package dncmd_pkg;

    localparam int WORD_W = 32;
    localparam int OFF_W  = 8;

    localparam logic [OFF_W-1:0] OFF_HDR0   = 8'h00;
    localparam logic [OFF_W-1:0] OFF_HDR1   = 8'h04;
    localparam logic [OFF_W-1:0] OFF_HDR2   = 8'h08;
    localparam logic [OFF_W-1:0] OFF_DATA   = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_IRQ_EN = 8'h6C;
    localparam logic [OFF_W-1:0] OFF_STATUS = 8'h70;

    localparam int BIT_DONE     = 28;
    localparam int BIT_NONFATAL = 6;
    localparam int BIT_FATAL    = 5;
    localparam int BIT_NORESP   = 4;
    localparam int BIT_CRC      = 2;
    localparam int BIT_WAITTO   = 1;
    localparam int BIT_BUSERR   = 0;
    localparam int BIT_START    = 3;
    localparam int HDR2_W       = 8;

    function automatic logic [WORD_W-1:0] bitw(input int b);
        return WORD_W'(1) << b;
    endfunction

    localparam logic [WORD_W-1:0] STATUS_MASK =
        bitw(BIT_DONE) | bitw(BIT_NONFATAL) | bitw(BIT_FATAL) |
        bitw(BIT_NORESP) | bitw(BIT_CRC) | bitw(BIT_WAITTO) | bitw(BIT_BUSERR);

    // bits 7:6 reserved, bit 3 is reported live rather than stored
    localparam logic [WORD_W-1:0] HDR0_STORE_MASK = 32'hFFFF_FF37;

    typedef enum logic [2:0] {
        CMD_SET_CFG    = 3'd0,
        CMD_GET_CFG    = 3'd1,
        CMD_INBAND_RST = 3'd2,
        CMD_UNUSED3    = 3'd3,
        CMD_PERIPH     = 3'd4,
        CMD_VWIRE      = 3'd5,
        CMD_OOB        = 3'd6,
        CMD_FLASH      = 3'd7
    } cmd_type_e;

    typedef enum logic [2:0] {
        CPL_OK       = 3'd0,
        CPL_NONFATAL = 3'd1,
        CPL_FATAL    = 3'd2,
        CPL_NORESP   = 3'd3,
        CPL_CRC      = 3'd4,
        CPL_WAITTO   = 3'd5,
        CPL_BUSERR   = 3'd6,
        CPL_OTHER    = 3'd7
    } cpl_code_e;

    typedef struct packed {
        logic [7:0] hb2;
        logic [7:0] hb1;
        logic [7:0] hb0;
        logic [1:0] rsvd;
        logic [1:0] target;
        logic       start;
        cmd_type_e  ctype;
    } hdr0_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } issue_st_e;

    function automatic logic [WORD_W-1:0] cpl_err_mask(input cpl_code_e c);
        logic [WORD_W-1:0] m;
        unique case (c)
            CPL_OK:       m = '0;
            CPL_NONFATAL: m = bitw(BIT_NONFATAL);
            CPL_FATAL:    m = bitw(BIT_FATAL);
            CPL_NORESP:   m = bitw(BIT_NORESP);
            CPL_CRC:      m = bitw(BIT_CRC);
            CPL_WAITTO:   m = bitw(BIT_WAITTO);
            CPL_BUSERR:   m = bitw(BIT_BUSERR);
            default:      m = bitw(BIT_FATAL);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dncmd_issue_fsm.sv
module dncmd_issue_fsm
    import dncmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic req_ready,
    input  logic cpl_valid,
    output logic busy,
    output logic req_valid,
    output logic cpl_take
);

    issue_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (launch)    st_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) st_d = ST_AWAIT;
            ST_AWAIT: if (cpl_valid) st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign busy      = (st_q != ST_IDLE);
    assign req_valid = (st_q == ST_ISSUE);
    assign cpl_take  = (st_q == ST_AWAIT) && cpl_valid;

endmodule

// File: rtl/dncmd_cmd_regs.sv
module dncmd_cmd_regs
    import dncmd_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              cpl_take,
    input  logic [2:0]        cpl_code,
    input  logic [WORD_W-1:0] cpl_word,
    output hdr0_t             hdr0,
    output logic [WORD_W-1:0] hdr1,
    output logic [HDR2_W-1:0] hdr2,
    output logic [WORD_W-1:0] data,
    output logic              launch
);

    hdr0_t             h0_q;
    logic [WORD_W-1:0] h1_q;
    logic [HDR2_W-1:0] h2_q;
    logic [WORD_W-1:0] d_q;

    logic sel_h0, sel_h1, sel_h2, sel_d, open_wr, capture;

    assign sel_h0  = (addr == ADDR_W'(OFF_HDR0));
    assign sel_h1  = (addr == ADDR_W'(OFF_HDR1));
    assign sel_h2  = (addr == ADDR_W'(OFF_HDR2));
    assign sel_d   = (addr == ADDR_W'(OFF_DATA));
    assign open_wr = wr_en && !busy;
    assign launch  = open_wr && sel_h0 && wdata[BIT_START];
    assign capture = cpl_take && (h0_q.ctype == CMD_GET_CFG) &&
                     (cpl_code_e'(cpl_code) == CPL_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            h0_q <= '0;
            h1_q <= '0;
            h2_q <= '0;
            d_q  <= '0;
        end else begin
            if (open_wr && sel_h0) h0_q <= hdr0_t'(wdata & HDR0_STORE_MASK);
            if (open_wr && sel_h1)  h1_q <= wdata;
            else if (capture)       h1_q <= cpl_word;
            if (open_wr && sel_h2) h2_q <= wdata[HDR2_W-1:0];
            if (open_wr && sel_d)  d_q  <= wdata;
        end
    end

    assign hdr0 = h0_q;
    assign hdr1 = h1_q;
    assign hdr2 = h2_q;
    assign data = d_q;

endmodule

// File: rtl/dncmd_status_regs.sv
module dncmd_status_regs
    import dncmd_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cpl_take,
    input  logic [2:0]        cpl_code,
    output logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] enable,
    output logic              irq
);

    logic [WORD_W-1:0] sts_q, en_q, set_vec, clr_vec;
    logic sel_sts, sel_en;

    assign sel_sts = (addr == ADDR_W'(OFF_STATUS));
    assign sel_en  = (addr == ADDR_W'(OFF_IRQ_EN));

    assign set_vec = cpl_take ? (bitw(BIT_DONE) | cpl_err_mask(cpl_code_e'(cpl_code)))
                              : '0;
    assign clr_vec = (wr_en && sel_sts) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= ((sts_q & ~clr_vec) | set_vec) & STATUS_MASK;
            if (wr_en && sel_en) en_q <= wdata & STATUS_MASK;
        end
    end

    assign status = sts_q;
    assign enable = en_q;
    assign irq    = |(sts_q & en_q);

endmodule

// File: rtl/dncmd_doorbell.sv
module dncmd_doorbell
    import dncmd_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_hdr0,
    output logic [31:0]       req_hdr1,
    output logic [7:0]        req_hdr2,
    output logic [31:0]       req_data,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_code,
    input  logic [31:0]       cpl_word,
    output logic              irq
);

    logic              wr_en, busy, launch, cpl_take;
    hdr0_t             hdr0_q;
    logic [WORD_W-1:0] hdr1_q, data_q, status_q, enable_q;
    logic [HDR2_W-1:0] hdr2_q;
    logic [WORD_W-1:0] hdr0_view;

    assign wr_en = bus_valid && bus_write;

    dncmd_issue_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .req_ready (req_ready),
        .cpl_valid (cpl_valid),
        .busy      (busy),
        .req_valid (req_valid),
        .cpl_take  (cpl_take)
    );

    dncmd_cmd_regs #(.ADDR_W(ADDR_W)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .busy     (busy),
        .cpl_take (cpl_take),
        .cpl_code (cpl_code),
        .cpl_word (cpl_word),
        .hdr0     (hdr0_q),
        .hdr1     (hdr1_q),
        .hdr2     (hdr2_q),
        .data     (data_q),
        .launch   (launch)
    );

    dncmd_status_regs #(.ADDR_W(ADDR_W)) u_sts (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cpl_take (cpl_take),
        .cpl_code (cpl_code),
        .status   (status_q),
        .enable   (enable_q),
        .irq      (irq)
    );

    always_comb begin
        hdr0_view            = hdr0_q;
        hdr0_view[BIT_START] = busy;
    end

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFF_HDR0))   bus_rdata = hdr0_view;
        else if (bus_addr == ADDR_W'(OFF_HDR1))   bus_rdata = hdr1_q;
        else if (bus_addr == ADDR_W'(OFF_HDR2))   bus_rdata = WORD_W'(hdr2_q);
        else if (bus_addr == ADDR_W'(OFF_DATA))   bus_rdata = data_q;
        else if (bus_addr == ADDR_W'(OFF_IRQ_EN)) bus_rdata = enable_q;
        else if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = status_q;
    end

    assign req_hdr0 = hdr0_view;
    assign req_hdr1 = hdr1_q;
    assign req_hdr2 = hdr2_q;
    assign req_data = data_q;

endmodule

// File: rtl/dncmd_doorbell_chk.sv
module dncmd_doorbell_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_hdr0,
    input logic [31:0] req_hdr1,
    input logic [7:0]  req_hdr2,
    input logic [31:0] req_data,
    input logic        cpl_valid,
    input logic [31:0] status,
    input logic [31:0] enable,
    input logic        irq
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_hdr0) &&
        $stable(req_hdr1) && $stable(req_hdr2) && $stable(req_data)); // R4

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_valid); // R4

    AST_CPL_FINISH: assert property (@(posedge clk) disable iff (rst)
        busy && !req_valid && cpl_valid |=> !busy && status[28]); // R7

    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ((status & ~$past(status)) == 32'h0)); // R5

    AST_LOCKED_WORDS: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(req_hdr2) && $stable(req_data)); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (status == 32'h0 || enable == 32'h0) |-> !irq); // R10

endmodule

bind dncmd_doorbell dncmd_doorbell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_hdr0  (req_hdr0),
    .req_hdr1  (req_hdr1),
    .req_hdr2  (req_hdr2),
    .req_data  (req_data),
    .cpl_valid (cpl_valid),
    .status    (status_q),
    .enable    (enable_q),
    .irq       (irq)
);

// File: tb/dncmd_doorbell_bench.sv
`timescale 1ns/100ps
module dncmd_doorbell_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [31:0] req_hdr0, req_hdr1, req_data;
    logic [7:0]  req_hdr2;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_code = 3'd0;
    logic [31:0] cpl_word = 32'h0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dncmd_doorbell u_dncmd_doorbell (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_hdr0(req_hdr0),
        .req_hdr1(req_hdr1), .req_hdr2(req_hdr2), .req_data(req_data),
        .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_word(cpl_word),
        .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    localparam logic [31:0] IMPL = 32'h1000_0077;
    logic [31:0] m_h0, m_h1, m_d, m_sts, m_en;
    logic [7:0]  m_h2;
    int          m_phase; // 0 idle, 1 offered, 2 awaiting completion

    function automatic logic [31:0] err_of(input logic [2:0] c);
        case (c)
            3'd1: return 32'h40;
            3'd2: return 32'h20;
            3'd3: return 32'h10;
            3'd4: return 32'h04;
            3'd5: return 32'h02;
            3'd6: return 32'h01;
            3'd7: return 32'h20;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_h0 | ((m_phase != 0) ? 32'h8 : 32'h0);
            8'h04: return m_h1;
            8'h08: return {24'h0, m_h2};
            8'h0C: return m_d;
            8'h6C: return m_en;
            8'h70: return m_sts;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_h0 = 0; m_h1 = 0; m_h2 = 0; m_d = 0; m_sts = 0; m_en = 0; m_phase = 0;
        end else begin
            automatic bit was_busy = (m_phase != 0);
            automatic int nphase = m_phase;
            automatic logic [31:0] nsts = m_sts;
            if (bus_valid && bus_write) begin
                case (bus_addr)
                    8'h00: if (!was_busy) begin
                        m_h0 = bus_wdata & 32'hFFFF_FF37;
                        if (bus_wdata[3]) nphase = 1;
                    end
                    8'h04: if (!was_busy) m_h1 = bus_wdata;
                    8'h08: if (!was_busy) m_h2 = bus_wdata[7:0];
                    8'h0C: if (!was_busy) m_d = bus_wdata;
                    8'h6C: m_en = bus_wdata & IMPL;
                    8'h70: nsts = nsts & ~bus_wdata;
                    default: ;
                endcase
            end
            if (m_phase == 1 && req_ready) nphase = 2;
            if (m_phase == 2 && cpl_valid) begin
                nphase = 0;
                nsts = nsts | 32'h1000_0000 | err_of(cpl_code);
                if (m_h0[2:0] == 3'd1 && cpl_code == 3'd0) m_h1 = cpl_word;
            end
            m_sts = nsts;
            m_phase = nphase;
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4", {31'h0, req_valid}, {31'h0, m_phase == 1}, "req_valid");
            chk("R10", {31'h0, irq}, {31'h0, |(m_sts & m_en)}, "irq");
            if (m_phase == 1) begin
                chk("R3", req_hdr0, m_h0 | 32'h8, "req_hdr0");
                chk("R3", req_hdr1, m_h1, "req_hdr1");
                chk("R3", {24'h0, req_hdr2}, {24'h0, m_h2}, "req_hdr2");
                chk("R3", req_data, m_d, "req_data");
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, m_read(a), $sformatf("read %h", a));
        @(negedge clk);
    endtask

    task automatic ready_pulse();
        req_ready = 1; @(negedge clk); req_ready = 0;
    endtask

    task automatic cpl(input logic [2:0] c, input logic [31:0] w);
        cpl_valid = 1; cpl_code = c; cpl_word = w;
        @(negedge clk);
        cpl_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
        rd(8'h0C, "R1"); rd(8'h6C, "R1"); rd(8'h70, "R1");
        // R2 layout and readback
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'h1234_5678);
        rd(8'h04, "R2"); rd(8'h08, "R2"); rd(8'h0C, "R2"); rd(8'h40, "R2");
        wr(8'h00, 32'hFFFF_FFF7);
        rd(8'h00, "R2");
        idle(2); // R3 no launch without start bit
        // R3 launch of a get-configuration command
        wr(8'h00, 32'h4433_2219);
        rd(8'h00, "R3");
        idle(3); // R4 held while not ready
        wr(8'h04, 32'h0);             // R6 ignored
        wr(8'h00, 32'h0000_000C);     // R6 ignored
        wr(8'h08, 32'h0);             // R6 ignored
        cpl(3'd2, 32'h0BAD_0BAD);     // R5 early completion ignored
        rd(8'h00, "R6"); rd(8'h04, "R6"); rd(8'h08, "R6"); rd(8'h70, "R5");
        ready_pulse();
        wr(8'h0C, 32'h0);             // R6 ignored while awaiting
        rd(8'h0C, "R6");
        cpl(3'd0, 32'hDEAD_BEEF);
        rd(8'h00, "R5"); rd(8'h04, "R9"); rd(8'h70, "R7");
        // R10 enable masking, R8 write-one-to-clear
        wr(8'h6C, 32'hFFFF_FFFF);
        rd(8'h6C, "R10");
        wr(8'h70, 32'h0);
        rd(8'h70, "R8");
        wr(8'h70, 32'h1000_0000);
        rd(8'h70, "R8");
        // R7 every completion code on a peripheral command
        for (int c = 1; c < 8; c++) begin
            wr(8'h00, 32'h0000_000C);
            ready_pulse();
            idle(1);
            cpl(3'(c), 32'hA0 + c);
            rd(8'h70, "R7"); rd(8'h04, "R9");
            wr(8'h70, 32'hFFFF_FFFF);
        end
        // R9 get-configuration with an error code keeps header word 1
        wr(8'h00, 32'h0000_0009);
        ready_pulse();
        cpl(3'd3, 32'h1111_1111);
        rd(8'h04, "R9"); rd(8'h70, "R7");
        wr(8'h70, 32'hFFFF_FFFF);
        // R8 set wins over same-cycle clear, with capture
        wr(8'h00, 32'h0000_0009);
        ready_pulse();
        bus_valid = 1; bus_write = 1; bus_addr = 8'h70; bus_wdata = 32'h1000_0000;
        cpl_valid = 1; cpl_code = 3'd0; cpl_word = 32'h55AA_55AA;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; cpl_valid = 0;
        rd(8'h70, "R8"); rd(8'h04, "R9");
        wr(8'h70, 32'hFFFF_FFFF);
        // R5 stray completion while idle
        cpl(3'd6, 32'h0);
        rd(8'h70, "R5");
        // R10 partial enable, virtual-wire command with target 3
        wr(8'h6C, 32'h0000_0020);
        wr(8'h00, 32'hAABB_CC3D);
        idle(1);
        ready_pulse();
        cpl(3'd2, 32'h0);
        rd(8'h70, "R10");
        wr(8'h70, 32'h0000_0020);
        rd(8'h70, "R10");
        idle(2);
        wr(8'h70, 32'hFFFF_FFFF);
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule